// File: doc/BRIEF.md
# Fractional Rate Clock Divider

This block derives a slower event stream and a slower clock from a reference clock. The average division ratio need not be a whole number. Two 12-bit counts, `L` and `M`, set the ratio: over time the output event rate divided by the input clock rate equals L / (4096 − M + L). The block gets a fractional average by using two neighbouring whole-number periods. Each output period is either the floor or the ceiling of the ideal ratio, and the two are mixed so that the average comes out exact. It is meant to sit in the clock path ahead of a sampler and to produce that sampler's conversion timing from the reference clock.

The counts on the input pins are taken in only when the load strobe is high. The same load restarts the sequence from a known state. A phase accumulator with modulus N = 4096 − M + L gains L on every input cycle. Each time it reaches or passes N, it drops N and produces one event. An event appears at the ports in two forms. One is a pulse one input cycle wide. The other is a registered clock output that toggles once per event, so its frequency is half the event rate and its duty is close to 50%.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is high, and after reset until the first load, `tick` and `div_clk` are both 0, whatever values are on `l_cnt` and `m_cnt`.
- R2: `l_cnt` and `m_cnt` affect the output only in the cycle where `load` is 1. Changing them while `load` is 0 leaves the ongoing event sequence unchanged.
- R3: The rising edge that samples `load` clears the phase, `tick` and `div_clk` to 0. With L > 0, the first `tick` is seen after the ceil(N/L)-th rising edge that follows the load edge.
- R4: Take N = 4096 − M + L, a 13-bit value. After a load, exactly L ticks occur in the first N input cycles. Tick k (counted from the load edge) is high exactly when floor(k·L/N) > floor((k−1)·L/N).
- R5: With L > 0, every spacing between consecutive ticks is floor(N/L) or ceil(N/L) input cycles. The spacing from the load edge to the first tick is one of these two values as well.
- R6: With L = 2 and M = 4089 (N = 9, average ratio 4.5), the first 36 cycles after a load contain four spacings of 4 cycles and four spacings of 5 cycles.
- R7: With L = 0, no tick occurs and `div_clk` stays 0 after the load.
- R8: `div_clk` inverts on every edge that raises `tick` and holds its value on every other edge. Its level therefore equals the parity of the ticks counted since the last load or reset.
- R9: Each event gives a `tick` pulse one input cycle wide. It is registered and appears on the edge after the one where the phase wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cnt | input | 12 | Phase increment count L |
| m_cnt | input | 12 | Modulus count M; the modulus is 4096 − M + L |
| load | input | 1 | Takes in `l_cnt`/`m_cnt` and restarts the sequence |
| tick | output | 1 | One-cycle event pulse |
| div_clk | output | 1 | Registered clock that toggles on each event |

## Verification
The load edge is edge 0. After edge k, `tick` shows whether floor(k·L/N) went up at that edge, and `div_clk` shows the parity of the ticks seen so far. There is no further delay. The bench drives inputs and samples outputs on the falling edge. After the falling edge that follows edge k, it compares both outputs with values computed from the division formula, one sample for each k. The counts per window and the spacing checks are built from the same per-cycle samples, so every expected value is tied to the edge that produces it.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned DEF_CNT_W = 12;

  // modulus N = 2^w - m + l
  function automatic int unsigned modulus_of(int unsigned l, int unsigned m, int unsigned w);
    return (32'd1 << w) - m + l;
  endfunction
endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg #(
  parameter int unsigned CNT_W = frac_div_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] l_in,
  input  logic [CNT_W-1:0] m_in,
  output logic [CNT_W-1:0] l_q,
  output logic [CNT_W:0]   n_q
);
  localparam int unsigned MOD_W = CNT_W + 1;

  logic [MOD_W-1:0] n_d;
  assign n_d = MOD_W'(frac_div_pkg::modulus_of(32'(l_in), 32'(m_in), CNT_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q <= '0;
      n_q <= {1'b1, {CNT_W{1'b0}}};
    end else if (load) begin
      l_q <= l_in;
      n_q <= n_d;
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(l_q) && $stable(n_q)));

  // R4
  incr_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    l_q < n_q);
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
  parameter int unsigned CNT_W = frac_div_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] l_q,
  input  logic [CNT_W:0]   n_q,
  output logic [CNT_W:0]   acc_q,
  output logic             wrap
);
  localparam int unsigned MOD_W = CNT_W + 1;
  localparam int unsigned SUM_W = CNT_W + 2;

  function automatic logic [SUM_W-1:0] sum_of(logic [MOD_W-1:0] acc, logic [CNT_W-1:0] inc);
    return {1'b0, acc} + {2'b00, inc};
  endfunction

  logic [SUM_W-1:0] sum;
  logic [MOD_W-1:0] acc_nxt;

  assign sum     = sum_of(acc_q, l_q);
  assign wrap    = (sum >= {1'b0, n_q});
  assign acc_nxt = wrap ? MOD_W'(sum - {1'b0, n_q}) : sum[MOD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else            acc_q <= acc_nxt;
  end

  // R4
  acc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q < n_q);

  // R3
  clr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));

  // R7
  idle_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (l_q == '0) |-> !wrap);
endmodule

// File: rtl/frac_div_out.sv
module frac_div_out (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wrap,
  output logic tick,
  output logic div_clk
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tick    <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      tick    <= wrap;
      div_clk <= div_clk ^ wrap;
    end
  end

  // R9
  tick_follows_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> tick);

  // R8
  div_clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (tick == (div_clk != $past(div_clk))));

  // R3
  clr_out_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!tick && !div_clk));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int unsigned CNT_W = frac_div_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] l_cnt,
  input  logic [CNT_W-1:0] m_cnt,
  input  logic             load,
  output logic             tick,
  output logic             div_clk
);
  logic [CNT_W-1:0] l_q;
  logic [CNT_W:0]   n_q;
  logic [CNT_W:0]   acc_q;
  logic             wrap_evt;

  frac_div_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .l_in(l_cnt), .m_in(m_cnt), .l_q(l_q), .n_q(n_q)
  );

  frac_div_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(load),
    .l_q(l_q), .n_q(n_q), .acc_q(acc_q), .wrap(wrap_evt)
  );

  frac_div_out u_out (
    .clk(clk), .rst(rst), .clr(load),
    .wrap(wrap_evt), .tick(tick), .div_clk(div_clk)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tick && !div_clk));
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] l_cnt = '0;
  logic [11:0] m_cnt = '0;
  logic        load = 1'b0;
  logic        tick;
  logic        div_clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rst(rst), .l_cnt(l_cnt), .m_cnt(m_cnt),
    .load(load), .tick(tick), .div_clk(div_clk)
  );

  task automatic check_eq(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint mod_of(longint l, longint m);
    return 64'd4096 - m + l;
  endfunction

  function automatic bit exp_tick(longint k, longint l, longint n);
    return ((k * l) / n) != (((k - 1) * l) / n);
  endfunction

  // returns counts of floor-length and ceil-length spacings
  task automatic run_case(int l, int m, int cycles, bit scramble,
                          output int n_lo, output int n_hi);
    longint n = mod_of(l, m);
    longint lo, hi;
    int win_ticks = 0, last = 0, first = 0;
    bit par = 0;
    n_lo = 0; n_hi = 0;
    lo = (l == 0) ? 0 : n / l;
    hi = (l == 0) ? 0 : (n + l - 1) / l;
    @(negedge clk);
    l_cnt = 12'(l); m_cnt = 12'(m); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check_eq("R3", "tick after load", tick, 0);
    check_eq("R3", "div_clk after load", div_clk, 0);
    for (int k = 1; k <= cycles; k++) begin
      if (scramble) begin
        l_cnt = 12'($urandom);
        m_cnt = 12'($urandom);
      end
      @(negedge clk);
      check_eq("R4", "tick pattern", tick, exp_tick(k, l, n));
      if (tick) begin
        par = ~par;
        if (k <= n) win_ticks++;
        if (first == 0) first = k;
        if ((k - last) == lo) n_lo++;
        else if ((k - last) == hi) n_hi++;
        else check_eq("R5", "tick spacing", k - last, hi);
        last = k;
      end
      check_eq("R8", "div_clk parity", div_clk, par);
    end
    if (cycles >= n) check_eq("R4", "ticks per N window", win_ticks, l);
    if (l != 0 && cycles >= hi) check_eq("R3", "first tick cycle", first, hi);
    if (l == 0) check_eq("R7", "idle div_clk", div_clk, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int a, b;
    void'($urandom(32'd20240611));
    // R1: reset and pre-load quiet
    l_cnt = 12'd7; m_cnt = 12'd4000;
    repeat (3) @(negedge clk);
    check_eq("R1", "tick in reset", tick, 0);
    check_eq("R1", "div_clk in reset", div_clk, 0);
    rst = 1'b0;
    for (int k = 0; k < 40; k++) begin
      l_cnt = 12'($urandom); m_cnt = 12'($urandom);
      @(negedge clk);
      check_eq("R1", "tick before load", tick, 0);
      check_eq("R1", "div_clk before load", div_clk, 0);
    end
    // R6: ratio 4.5
    run_case(2, 4089, 36, 1'b0, a, b);
    check_eq("R6", "divide-by-4 spacings", a, 4);
    check_eq("R6", "divide-by-5 spacings", b, 4);
    // R7: idle
    run_case(0, 4000, 120, 1'b0, a, b);
    check_eq("R7", "idle tick count", a + b, 0);
    // directed edges
    run_case(1, 4095, 10, 1'b0, a, b);
    run_case(4095, 4095, 4096, 1'b0, a, b);
    run_case(4095, 0, 8191, 1'b0, a, b);
    run_case(1, 0, 4097, 1'b0, a, b);
    // R2: inputs change without load mid-run
    run_case(5, 4080, 60, 1'b1, a, b);
    // random
    for (int c = 0; c < 20; c++) begin
      int n = $urandom_range(400, 1);
      int l = $urandom_range(n - 1, 0);
      run_case(l, 4096 - n + l, n + $urandom_range(30, 0), 1'b1, a, b);
    end
    // R1: reset mid-run
    run_case(3, 4090, 5, 1'b0, a, b);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check_eq("R1", "tick after mid reset", tick, 0);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule